// File: doc/BRIEF.md
# Two-Wire Serial Memory Write Slave

This block is the write side of a serial memory that sits on a two-wire bus with one clock line and one open-drain data line. It samples both lines with the system clock and finds start and stop conditions. It frames each byte and answers the master by pulling the data line low during the ninth clock of a byte. The first byte after a start picks the device and the direction. Two word-address bytes follow it, high byte first. All later bytes are data. They are collected in a page buffer that holds 32 entries.

Nothing reaches the memory array while bytes arrive. A stop condition copies every buffered byte into the array in one cycle. The stop also starts a busy interval whose length is a parameter. For that whole interval the block does not react to the bus. A narrow read port lets neighbouring logic look at any array byte.

Top module: `twowire_page_writer`

## Requirements
- R1: The first byte after a start is acknowledged only if all three of these hold: bits 7..4 equal 1010, bits 3..1 equal the DEV_SEL parameter, and bit 0 (the direction bit) is 0. Any other first byte gets no acknowledge. The block then stays silent and stores nothing until the next start.
- R2: When the first byte matches, the block acknowledges the next two bytes, which form the word address with the high byte first. The low log2(MEM_DEPTH) bits of the 16-bit address select the array byte, so word address 0x1207 selects byte 0x07 when MEM_DEPTH is 256.
- R3: Every data byte is acknowledged by sda_oe = 1 during the ninth clock, up to 32 data bytes in one transaction. A 33rd or later data byte gets no acknowledge and is not stored.
- R4: After each stored data byte, only address bits 4..0 advance by one, wrapping from 31 to 0. Bits above bit 4 stay the same, so every byte of a transaction lands in the same 32-byte page.
- R5: The array changes only on a stop. The stop writes exactly the locations that received data in that transaction. A single data byte changes one location and leaves the rest of its page alone.
- R6: A stop before any data byte has completed starts no write cycle, and busy stays 0. A start, including a repeated start, throws away all bytes buffered since the previous start.
- R7: A stop that ends a transaction with stored data raises busy within four clocks. Busy then stays 1 for exactly BUSY_CYCLES consecutive clocks.
- R8: While busy is 1, sda_oe stays 0. Starts, stops and bytes are ignored, and the array keeps its contents. A transaction that follows the busy interval is handled normally.
- R9: After reset, sda_oe and busy are 0 and every array byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge); 0 releases it |
| busy | output | 1 | 1 while a write cycle to the array is running |
| peek_addr | input | log2(MEM_DEPTH) | Array byte to look at |
| peek_data | output | 8 | Contents of the array byte at peek_addr |

## Verification
The assertions assume that the data line changes only while the clock line is low, except at start and stop conditions. They also assume that each bus phase lasts several system clocks, so the three-stage sampler sees every level. The bench drives every bus phase for six system clocks and changes the data line only in the middle of the low phase. It always releases the line during the ninth clock. The ignored transaction is kept shorter than the busy interval, so it ends entirely inside that interval.

// File: rtl/tw_wr_pkg.sv
`timescale 1ns/1ps
package tw_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RECV,
    PH_ACKW,
    PH_ACK,
    PH_WAIT
  } phase_t;

  typedef enum logic [1:0] {
    BK_DEV,
    BK_AHI,
    BK_ALO,
    BK_DATA
  } kind_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // Selection byte check: type code, select bits and write direction.
  function automatic logic dev_write_match(input logic [7:0] b, input logic [2:0] sel);
    return (b[7:4] == DEV_TYPE) && (b[3:1] == sel) && !b[0];
  endfunction

  // Serial byte assembly, most significant bit first.
  function automatic logic [7:0] shift_in(input logic [7:0] sr, input logic bit_in);
    return {sr[6:0], bit_in};
  endfunction

endpackage

// File: rtl/tw_bus_sense.sv
`timescale 1ns/1ps
module tw_bus_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_bit,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [1:0] scl_sync;
  logic [1:0] sda_sync;
  logic       scl_prev;
  logic       sda_prev;
  logic       scl_now;

  // Idle bus reads high, so reset to 1 so that no false condition appears.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_prev <= scl_sync[1];
      sda_prev <= sda_sync[1];
    end
  end

  assign scl_now   = scl_sync[1];
  assign sda_bit   = sda_sync[1];
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_evt = scl_now & scl_prev & sda_prev & ~sda_bit;
  assign stop_evt  = scl_now & scl_prev & ~sda_prev & sda_bit;

endmodule

// File: rtl/tw_write_fsm.sv
`timescale 1ns/1ps
module tw_write_fsm
  import tw_wr_pkg::*;
#(
  parameter int         PAGE_BYTES = 32,
  parameter int         MEM_AW     = 8,
  parameter logic [2:0] DEV_SEL    = 3'b000,
  localparam int        OFF_W      = $clog2(PAGE_BYTES),
  localparam int        PG_W       = MEM_AW - OFF_W,
  localparam int        CNT_W      = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             sda_bit,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  output logic             sda_oe,
  output logic             buf_clr,
  output logic             buf_we,
  output logic [OFF_W-1:0] buf_off,
  output logic [7:0]       buf_data,
  output logic             commit,
  output logic [PG_W-1:0]  page_idx
);

  phase_t           phase_q;
  kind_t            kind_q;
  logic [2:0]       bit_q;
  logic [7:0]       sr_q;
  logic [PG_W-1:0]  page_q;
  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] cnt_q;
  logic             oe_q;

  logic [7:0]       byte_now;
  logic             byte_done;
  logic             room;
  logic             ack_now;

  // Place one address byte into the 16-bit word address and keep the page bits.
  function automatic logic [PG_W-1:0] put_addr_byte(input logic [PG_W-1:0] pg,
                                                     input logic [7:0] b,
                                                     input logic hi);
    logic [15:0] t;
    t = 16'(pg) << OFF_W;
    if (hi) t[15:8] = b;
    else    t[7:0]  = b;
    return t[MEM_AW-1:OFF_W];
  endfunction

  // The offset inside the page wraps at the page size.
  function automatic logic [OFF_W-1:0] next_off(input logic [OFF_W-1:0] o);
    return o + 1'b1;
  endfunction

  assign byte_now  = shift_in(sr_q, sda_bit);
  assign byte_done = !busy && !start_evt && !stop_evt && (phase_q == PH_RECV) &&
                     scl_rise && (bit_q == 3'd7);
  assign room      = cnt_q < CNT_W'(PAGE_BYTES);

  always_comb begin
    unique case (kind_q)
      BK_DEV:  ack_now = dev_write_match(byte_now, DEV_SEL);
      BK_AHI:  ack_now = 1'b1;
      BK_ALO:  ack_now = 1'b1;
      default: ack_now = room;
    endcase
  end

  assign buf_we   = byte_done && (kind_q == BK_DATA) && room;
  assign buf_off  = off_q;
  assign buf_data = byte_now;
  assign buf_clr  = start_evt && !busy;
  assign commit   = stop_evt && !busy && (cnt_q != '0);
  assign page_idx = page_q;
  assign sda_oe   = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kind_q  <= BK_DEV;
      bit_q   <= '0;
      sr_q    <= '0;
      page_q  <= '0;
      off_q   <= '0;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (busy) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (start_evt) begin
      phase_q <= PH_RECV;
      kind_q  <= BK_DEV;
      bit_q   <= '0;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_evt) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_RECV: begin
          if (scl_rise) begin
            sr_q  <= byte_now;
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              phase_q <= ack_now ? PH_ACKW : PH_WAIT;
              unique case (kind_q)
                BK_DEV: kind_q <= BK_AHI;
                BK_AHI: begin
                  page_q <= put_addr_byte(page_q, byte_now, 1'b1);
                  kind_q <= BK_ALO;
                end
                BK_ALO: begin
                  page_q <= put_addr_byte(page_q, byte_now, 1'b0);
                  off_q  <= byte_now[OFF_W-1:0];
                  kind_q <= BK_DATA;
                end
                default: begin
                  if (room) begin
                    off_q <= next_off(off_q);
                    cnt_q <= cnt_q + 1'b1;
                  end
                end
              endcase
            end
          end
        end
        PH_ACKW: begin
          if (scl_fall) begin
            oe_q    <= 1'b1;
            phase_q <= PH_ACK;
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            oe_q    <= 1'b0;
            phase_q <= PH_RECV;
          end
        end
        default: ;
      endcase
    end
  end

  // R8: the line is never pulled low during a write cycle.
  assert_quiet_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R1: an acknowledge begins only after a falling clock edge seen on the bus.
  assert_ack_after_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R6: a start releases the line in the cycle after it.
  assert_start_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !busy) |=> !sda_oe);

endmodule

// File: rtl/tw_page_store.sv
`timescale 1ns/1ps
module tw_page_store #(
  parameter int  PAGE_BYTES = 32,
  parameter int  MEM_DEPTH  = 256,
  localparam int MEM_AW     = $clog2(MEM_DEPTH),
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int PG_W       = MEM_AW - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clr,
  input  logic              buf_we,
  input  logic [OFF_W-1:0]  buf_off,
  input  logic [7:0]        buf_data,
  input  logic              commit,
  input  logic [PG_W-1:0]   page_idx,
  input  logic [MEM_AW-1:0] peek_addr,
  output logic [7:0]        peek_data
);

  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic [MEM_DEPTH*8-1:0] cells_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else if (buf_clr) begin
      mask_q <= '0;
    end else if (buf_we) begin
      mask_q[buf_off] <= 1'b1;
      pbuf[buf_off]   <= buf_data;
    end
  end

  // Each array byte takes its buffer entry when its page is committed and the entry was loaded.
  for (genvar j = 0; j < MEM_DEPTH; j++) begin : g_cell
    localparam int CELL_PG  = j / PAGE_BYTES;
    localparam int CELL_OFF = j % PAGE_BYTES;
    logic [7:0] cell_q;
    logic       cell_we;
    assign cell_we = commit && (page_idx == PG_W'(CELL_PG)) && mask_q[CELL_OFF];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= '0;
      else if (cell_we) cell_q <= pbuf[CELL_OFF];
    end
    assign cells_flat[j*8 +: 8] = cell_q;
  end

  assign peek_data = cells_flat[peek_addr*8 +: 8];

  // R4: the wrapping offset never lands on an entry already loaded in this transaction.
  assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !mask_q[buf_off]);

  // R6: a commit always has at least one buffered byte behind it.
  assert_commit_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (mask_q != '0));

endmodule

// File: rtl/tw_busy_timer.sv
`timescale 1ns/1ps
module tw_busy_timer #(
  parameter int  BUSY_CYCLES = 4000,
  localparam int CW          = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  output logic busy
);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (commit)         left_q <= CW'(BUSY_CYCLES);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

  // R7: a commit opens the busy interval on the next clock.
  assert_busy_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  // R8: no new commit arrives while a write cycle is running.
  assert_no_recommit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !busy);

endmodule

// File: rtl/twowire_page_writer.sv
`timescale 1ns/1ps
module twowire_page_writer #(
  parameter int         PAGE_BYTES  = 32,
  parameter int         MEM_DEPTH   = 256,
  parameter int         BUSY_CYCLES = 4000,
  parameter logic [2:0] DEV_SEL     = 3'b000,
  localparam int        MEM_AW      = $clog2(MEM_DEPTH),
  localparam int        OFF_W       = $clog2(PAGE_BYTES),
  localparam int        PG_W        = MEM_AW - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              busy,
  input  logic [MEM_AW-1:0] peek_addr,
  output logic [7:0]        peek_data
);

  logic             sda_bit;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_evt;
  logic             stop_evt;
  logic             buf_clr;
  logic             buf_we;
  logic [OFF_W-1:0] buf_off;
  logic [7:0]       buf_data;
  logic             commit;
  logic [PG_W-1:0]  page_idx;

  tw_bus_sense i_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_bit   (sda_bit),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  tw_write_fsm #(
    .PAGE_BYTES (PAGE_BYTES),
    .MEM_AW     (MEM_AW),
    .DEV_SEL    (DEV_SEL)
  ) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .sda_bit   (sda_bit),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_oe    (sda_oe),
    .buf_clr   (buf_clr),
    .buf_we    (buf_we),
    .buf_off   (buf_off),
    .buf_data  (buf_data),
    .commit    (commit),
    .page_idx  (page_idx)
  );

  tw_page_store #(
    .PAGE_BYTES (PAGE_BYTES),
    .MEM_DEPTH  (MEM_DEPTH)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_clr   (buf_clr),
    .buf_we    (buf_we),
    .buf_off   (buf_off),
    .buf_data  (buf_data),
    .commit    (commit),
    .page_idx  (page_idx),
    .peek_addr (peek_addr),
    .peek_data (peek_data)
  );

  tw_busy_timer #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) i_busy (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .busy   (busy)
  );

endmodule

// File: tb/test_twowire_page_writer.sv
`timescale 1ns/1ps
module test_twowire_page_writer;

  localparam int         BUSY  = 2000;
  localparam logic [2:0] SEL   = 3'b101;
  localparam int         DEPTH = 256;
  localparam int         Q     = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic       busy;
  logic [7:0] peek_addr = '0;
  logic [7:0] peek_data;
  wire        sda_line = sda_m & ~sda_oe;

  int         checks = 0;
  int         fails = 0;
  int         stray = 0;
  int         busy_run = 0;
  int         cyc = 0;
  bit         ack_slot = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] txd [40];

  always #2.5 clk = ~clk;

  twowire_page_writer #(
    .PAGE_BYTES  (32),
    .MEM_DEPTH   (DEPTH),
    .BUSY_CYCLES (BUSY),
    .DEV_SEL     (SEL)
  ) i_twowire_page_writer (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_m),
    .sda_in    (sda_line),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .peek_addr (peek_addr),
    .peek_data (peek_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
  endtask

  // Per-clock monitor: drive only in acknowledge slots, never while busy; busy length.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe && (!ack_slot || busy)) stray++;
      if (busy) busy_run++;
      else if (busy_run != 0) begin
        check(busy_run == BUSY, "R7 busy length", busy_run, BUSY);
        busy_run = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(Q);
  endtask

  task automatic clk_bit(input logic b);
    sda_m = b;    hold(Q);
    scl_m = 1'b1; hold(2*Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) ack_slot = 1;
      clk_bit(b[i]);
    end
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    check(sda_oe == exp_ack, req, int'(sda_oe), int'(exp_ack));
    hold(Q);
    scl_m = 1'b0; hold(Q);
    ack_slot = 0;
  endtask

  function automatic bit dev_ok_fn(input logic [7:0] d);
    return (d[7:4] == 4'hA) && (d[3:1] == SEL) && (d[0] == 1'b0);
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < 40; i++) txd[i] = 8'((seed * 13 + i * 7 + 1) & 255);
  endtask

  task automatic write_txn(input logic [7:0] dev, input logic [7:0] hi, input logic [7:0] lo,
                           input int n, input bit do_stop, input bit ignored,
                           input bit wait_done, input string req);
    bit ok;
    int idx;
    int pg;
    ok = !ignored && dev_ok_fn(dev);
    bus_start();
    send_byte(dev, ok, req);
    send_byte(hi, ok, req);
    send_byte(lo, ok, req);
    for (int i = 0; i < n; i++) send_byte(txd[i], ok && (i < 32), req);
    if (do_stop) begin
      bus_stop();
      if (ok && n > 0) begin
        idx = int'({hi, lo}) % DEPTH;
        pg  = idx & ~31;
        for (int i = 0; i < n && i < 32; i++) model[pg + ((idx + i) & 31)] = txd[i];
        check(busy == 1'b1, "R7 busy after stop", int'(busy), 1);
        if (wait_done) while (busy) @(negedge clk);
      end else if (!ignored) begin
        hold(10);
        check(busy == 1'b0, "R6 no write cycle", int'(busy), 0);
      end
    end
  endtask

  task automatic check_mem(input string req);
    int bad;
    int first_a;
    int first_act;
    int first_exp;
    bad = 0;
    first_a = 0;
    first_act = 0;
    first_exp = 0;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      peek_addr = 8'(a);
      #1;
      if (peek_data !== model[a]) begin
        if (bad == 0) begin
          first_a = a;
          first_act = int'(peek_data);
          first_exp = int'(model[a]);
        end
        bad++;
      end
    end
    check(bad == 0, $sformatf("%s array byte %0d", req, first_a), first_act, first_exp);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
    hold(5);
    rst_n = 1'b1;
    hold(2);

    // R9: reset state
    check(sda_oe == 1'b0, "R9 sda_oe reset", int'(sda_oe), 0);
    check(busy == 1'b0, "R9 busy reset", int'(busy), 0);
    check_mem("R9");

    // R2 R5: single byte write, high address byte beyond the array is dropped
    fill(1);
    write_txn(8'hAA, 8'h01, 8'h23, 1, 1, 0, 1, "R2 R3 byte write ack");
    check_mem("R5 byte write");

    // R4: full page starting at offset 28 wraps inside page 0x40
    fill(2);
    write_txn(8'hAA, 8'h00, 8'h5C, 32, 1, 0, 1, "R3 page ack");
    check_mem("R4 page wrap");

    // R3: bytes 33 and 34 are refused and not stored
    fill(3);
    write_txn(8'hAA, 8'h00, 8'hA3, 34, 1, 0, 1, "R3 overflow ack");
    check_mem("R3 overflow");

    // R1: wrong type code, wrong select bits, read direction
    fill(4);
    write_txn(8'hBA, 8'h00, 8'h10, 2, 1, 0, 1, "R1 wrong type");
    write_txn(8'hA8, 8'h00, 8'h11, 1, 1, 0, 1, "R1 wrong select");
    write_txn(8'hAB, 8'h00, 8'h12, 1, 1, 0, 1, "R1 read bit");
    check_mem("R1 no store");

    // R6: stop right after the address
    write_txn(8'hAA, 8'h00, 8'h14, 0, 1, 0, 1, "R6 address only");

    // R6: repeated start discards two buffered bytes
    fill(5);
    write_txn(8'hAA, 8'h00, 8'h30, 2, 0, 0, 1, "R6 first part");
    fill(6);
    write_txn(8'hAA, 8'h00, 8'h31, 1, 1, 0, 1, "R6 after restart");
    check_mem("R6 restart discard");

    // R8: traffic during the write cycle is ignored
    fill(7);
    write_txn(8'hAA, 8'h12, 8'h07, 1, 1, 0, 0, "R2 high byte ignored");
    fill(8);
    write_txn(8'hAA, 8'h00, 8'h60, 2, 1, 1, 0, "R8 no ack while busy");
    check(busy == 1'b1, "R8 still busy after ignored stop", int'(busy), 1);
    while (busy) @(negedge clk);
    check_mem("R8 ignored traffic");
    fill(9);
    write_txn(8'hAA, 8'h00, 8'h61, 1, 1, 0, 1, "R8 recovery ack");
    check_mem("R8 recovery");

    check(stray == 0, "R8 R1 stray line drive", stray, 0);
    summary();
    $finish;
  end

endmodule